// File: doc/BRIEF.md
# Framed 32-bit Serial DAC Command Receiver

This block is the receiving end of the serial control port of an eight-channel, 16-bit DAC. A host drives an active-low frame select, a serial clock that idles high, and a data line. The block samples the data line on each falling serial-clock edge while the frame select is low, most significant bit first. Once exactly 32 bits have arrived, it splits the word into its fields and, for a write-to-input-register command, loads the 16-bit value into the addressed channel register and raises a one-cycle update strobe.

All three serial inputs are asynchronous to the system clock. Each one passes through a multi-flop synchronizer, and edges are detected in the system clock domain, so the serial clock must be several times slower than the system clock. The block also flags malformed traffic. A frame closed before its 32nd bit raises a frame error. A word whose leading bit is set raises a protocol error. A command code other than zero raises an unsupported-command flag. None of these writes a register.

Top module: `serial_dac_rx`

## Requirements
- R1: After reset, every channel register reads zero and upd_strobe, frame_err, proto_err and cmd_unsup are all low.
- R2: A 32-bit frame with bit 31 = 0 and control bits 27:24 = 0 loads bits 19:4 into the channel register addressed by bits 23:20 (0 = first channel). The channel register sits at ch_data[16*ch +: 16].
- R3: Each successful write gives exactly one upd_strobe pulse, one system clock wide, with upd_chan carrying the address written. No pulse occurs without a write.
- R4: Bits are taken MSB first, one per falling sclk edge while sync_n is low. For example, full-scale data to channel 0 is the word 0x000FFFF0.
- R5: An address of CHANNELS or above (8..15 by default) writes nothing and gives no strobe.
- R6: If sync_n rises after fewer than 32 falling sclk edges in the frame, the partial word is dropped, no register changes, and frame_err pulses for one cycle.
- R7: A completed word with bit 31 = 1 writes nothing and pulses proto_err for one cycle. cmd_unsup stays low for that word.
- R8: A completed word with bit 31 = 0 and a nonzero control code writes nothing and pulses cmd_unsup for one cycle.
- R9: Falling sclk edges after the 32nd within one frame are ignored: no second write, and the data stored is that of the first 32 bits.
- R10: Bits 30:28 and 3:0 do not affect the write, and sclk activity while sync_n is high shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high, asynchronous |
| sync_n | input | 1 | Active-low frame select, asynchronous |
| din | input | 1 | Serial data, MSB first |
| upd_strobe | output | 1 | One-cycle pulse on a committed write |
| upd_chan | output | ADDR_W (4) | Channel written by the latest commit |
| ch_data | output | CHANNELS*DATA_W (128) | All channel registers, channel i at [16*i +: 16] |
| frame_err | output | 1 | One-cycle pulse for a frame ended early |
| proto_err | output | 1 | One-cycle pulse for a set leading bit |
| cmd_unsup | output | 1 | One-cycle pulse for a nonzero command code |

## Verification
Assertions are checked on every clock cycle. They require every strobe and error flag to be a single-cycle pulse, forbid a strobe alongside a frame or protocol error, keep the bit counter within one frame, and hold the channel registers still unless a completed word is present. Only the bench scenarios can show the decoded values landing in the right channel. The same applies to the field positions and bit order, the rejection of early-closed frames, surplus bits and out-of-range addresses, and the fact that don't-care bits and idle clocking leave the stored data untouched.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned FEAT_W    = 4;
   localparam int unsigned DATA_W    = 16;
   localparam int unsigned ADDR_W    = 4;
   localparam int unsigned CTRL_W    = 4;
   localparam int unsigned DATA_LSB  = FEAT_W;
   localparam int unsigned ADDR_LSB  = DATA_LSB + DATA_W;
   localparam int unsigned CTRL_LSB  = ADDR_LSB + ADDR_W;
   localparam int unsigned LEAD_BIT  = WORD_BITS - 1;

   typedef enum logic [CTRL_W-1:0] {
      OP_LOAD_INPUT = 4'h0
   } dac_op_e;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dacrx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= IDLE;
         else if (s == 0) pipe[s] <= d;
         else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacrx_shifter.sv
module dacrx_shifter #(
   parameter int unsigned BITS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk_s,
   input  logic            sel_n_s,
   input  logic            din_s,
   output logic [BITS-1:0] word,
   output logic            word_done,
   output logic            short_frame
);
   localparam int unsigned CNT_W = $clog2(BITS + 1);

   if (BITS < 2) begin : g_bad_bits
      $error("dacrx_shifter: BITS must be at least 2");
   end

   logic             sclk_q, sel_q;
   logic [CNT_W-1:0] cnt;
   logic             sclk_fall, sel_fall, sel_rise;

   assign sclk_fall = sclk_q & ~sclk_s;
   assign sel_fall  = sel_q & ~sel_n_s;
   assign sel_rise  = ~sel_q & sel_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q      <= 1'b1;
         sel_q       <= 1'b1;
         cnt         <= '0;
         word        <= '0;
         word_done   <= 1'b0;
         short_frame <= 1'b0;
      end else begin
         sclk_q      <= sclk_s;
         sel_q       <= sel_n_s;
         word_done   <= 1'b0;
         short_frame <= 1'b0;
         if (sel_fall) begin
            cnt <= '0;
         end else if (sel_rise) begin
            if (cnt != CNT_W'(BITS)) short_frame <= 1'b1;
            cnt <= '0;
         end else if (!sel_n_s && sclk_fall && cnt < CNT_W'(BITS)) begin
            word <= {word[BITS-2:0], din_s};
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(BITS - 1)) word_done <= 1'b1;
         end
      end
   end

   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(BITS));
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> !word_done);
   a_r6_short_single: assert property (@(posedge clk) disable iff (!rst_n)
      short_frame |=> !short_frame);
   a_r6_short_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      short_frame |-> !word_done);
endmodule

// File: rtl/dacrx_bank.sv
module dacrx_bank
   import dacrx_pkg::*;
#(
   parameter int unsigned CHANNELS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         word_done,
   input  logic [WORD_BITS-1:0]         word,
   output logic                         upd_strobe,
   output logic [ADDR_W-1:0]            upd_chan,
   output logic [CHANNELS*DATA_W-1:0]   ch_data,
   output logic                         proto_err,
   output logic                         cmd_unsup
);
   if (CHANNELS < 1 || CHANNELS > (1 << ADDR_W)) begin : g_bad_channels
      $error("dacrx_bank: CHANNELS out of address range");
   end

   logic              lead;
   logic [CTRL_W-1:0] op;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] value;
   logic              accept;

   assign lead   = word[LEAD_BIT];
   assign op     = word[CTRL_LSB +: CTRL_W];
   assign addr   = word[ADDR_LSB +: ADDR_W];
   assign value  = word[DATA_LSB +: DATA_W];
   assign accept = word_done && !lead && (op == OP_LOAD_INPUT)
                   && (32'(addr) < CHANNELS);

   for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else if (accept && addr == ADDR_W'(i)) r <= value;
      end
      assign ch_data[i*DATA_W +: DATA_W] = r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_strobe <= 1'b0;
         upd_chan   <= '0;
         proto_err  <= 1'b0;
         cmd_unsup  <= 1'b0;
      end else begin
         upd_strobe <= accept;
         proto_err  <= word_done && lead;
         cmd_unsup  <= word_done && !lead && (op != OP_LOAD_INPUT);
         if (accept) upd_chan <= addr;
      end
   end

   a_r7_proto_excl: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> (!upd_strobe && !cmd_unsup));
   a_r8_unsup_excl: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_unsup |-> !upd_strobe);
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      upd_strobe |=> !upd_strobe);
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |=> $stable(ch_data));
endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
   import dacrx_pkg::*;
#(
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sclk,
   input  logic                       sync_n,
   input  logic                       din,
   output logic                       upd_strobe,
   output logic [ADDR_W-1:0]          upd_chan,
   output logic [CHANNELS*DATA_W-1:0] ch_data,
   output logic                       frame_err,
   output logic                       proto_err,
   output logic                       cmd_unsup
);
   logic [2:0]           synced;
   logic [WORD_BITS-1:0] word;
   logic                 word_done;

   dacrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sclk, sync_n, din}), .q(synced));

   dacrx_shifter #(.BITS(WORD_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(synced[2]), .sel_n_s(synced[1]), .din_s(synced[0]),
      .word(word), .word_done(word_done), .short_frame(frame_err));

   dacrx_bank #(.CHANNELS(CHANNELS)) u_bank (
      .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
      .upd_strobe(upd_strobe), .upd_chan(upd_chan), .ch_data(ch_data),
      .proto_err(proto_err), .cmd_unsup(cmd_unsup));

   a_r6_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !upd_strobe);
endmodule

// File: tb/sim_serial_dac_rx.sv
`timescale 1ns/1ps
module sim_serial_dac_rx;
   localparam int CH = 8;
   localparam int HALF = 4;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, sync_n = 1'b1, din = 1'b0;
   logic upd_strobe, frame_err, proto_err, cmd_unsup;
   logic [3:0] upd_chan;
   logic [CH*16-1:0] ch_data;

   int n_chk = 0, n_bad = 0;
   int n_upd = 0, n_ferr = 0, n_perr = 0, n_unsup = 0;
   logic [3:0] last_chan = '0;
   logic [15:0] model [CH];

   always #4 clk = ~clk;

   serial_dac_rx u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
      .din(din), .upd_strobe(upd_strobe), .upd_chan(upd_chan), .ch_data(ch_data),
      .frame_err(frame_err), .proto_err(proto_err), .cmd_unsup(cmd_unsup));

   always @(negedge clk) begin
      if (upd_strobe) begin n_upd++; last_chan = upd_chan; end
      if (frame_err) n_ferr++;
      if (proto_err) n_perr++;
      if (cmd_unsup) n_unsup++;
   end

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [63:0] bits, input int nbits);
      @(negedge clk);
      sync_n = 1'b0;
      wait_clk(HALF);
      for (int i = nbits - 1; i >= 0; i--) begin
         din = bits[i];
         wait_clk(HALF);
         sclk = 1'b0;
         wait_clk(HALF);
         sclk = 1'b1;
      end
      wait_clk(HALF);
      sync_n = 1'b1;
      wait_clk(12);
   endtask

   function automatic logic [31:0] mk(input logic lead, input logic [2:0] dc,
      input logic [3:0] op, input logic [3:0] a, input logic [15:0] d,
      input logic [3:0] f);
      return {lead, dc, op, a, d, f};
   endfunction

   task automatic check_bank(input string req);
      for (int i = 0; i < CH; i++)
         check(req, ch_data[i*16 +: 16], model[i]);
   endtask

   task automatic write_ok(input string req, input logic [31:0] w);
      int u0c;
      u0c = n_upd;
      send({32'h0, w}, 32);
      model[w[23:20]] = w[19:4];
      check(req, n_upd - u0c, 1);
      check(req, last_chan, w[23:20]);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] pats [6];
      int u, e;
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8000;
      pats[3] = 16'h0001; pats[4] = 16'hAAAA; pats[5] = 16'h5555;
      for (int i = 0; i < CH; i++) model[i] = '0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // R1 reset state
      check("R1", ch_data, 0);
      check("R1", {upd_strobe, frame_err, proto_err, cmd_unsup}, 0);

      // R4 full scale to channel 0 is 0x000FFFF0
      write_ok("R4", 32'h000FFFF0);
      check_bank("R4");

      // R2 sweep every channel with arithmetic data
      for (int c = 0; c < CH; c++)
         write_ok("R2", mk(1'b0, 3'b000, 4'h0, 4'(c), 16'(16'h1357 * (c + 3) ^ (c << 12)), 4'h0));
      check_bank("R2");

      // R4 bit order patterns on one channel
      for (int p = 0; p < 6; p++) begin
         write_ok("R4", mk(1'b0, 3'b000, 4'h0, 4'd5, pats[p], 4'h0));
         check("R4", ch_data[5*16 +: 16], pats[p]);
      end

      // R10 don't-care bits set
      write_ok("R10", mk(1'b0, 3'b111, 4'h0, 4'd2, 16'hC3A5, 4'hF));
      check_bank("R10");

      // R5 out-of-range addresses
      for (int a = CH; a < 16; a++) begin
         u = n_upd;
         send({32'h0, mk(1'b0, 3'b000, 4'h0, 4'(a), 16'hDEAD, 4'h0)}, 32);
         check("R5", n_upd - u, 0);
      end
      check_bank("R5");

      // R6 short frames
      foreach (pats[k]) begin
         u = n_upd; e = n_ferr;
         send({32'h0, mk(1'b0, 3'b000, 4'h0, 4'd1, 16'hBEEF, 4'h0)} >> (k + 3), 29 - k);
         check("R6", n_ferr - e, 1);
         check("R6", n_upd - u, 0);
      end
      check_bank("R6");

      // R7 leading bit set
      u = n_upd; e = n_perr;
      send({32'h0, mk(1'b1, 3'b000, 4'h0, 4'd3, 16'h1111, 4'h0)}, 32);
      check("R7", n_perr - e, 1);
      check("R7", n_upd - u, 0);
      e = n_unsup;
      send({32'h0, mk(1'b1, 3'b000, 4'h3, 4'd3, 16'h2222, 4'h0)}, 32);
      check("R7", n_unsup - e, 0);
      check_bank("R7");

      // R8 nonzero command codes
      for (int op = 1; op < 16; op++) begin
         u = n_upd; e = n_unsup;
         send({32'h0, mk(1'b0, 3'b000, 4'(op), 4'd4, 16'h7777, 4'h0)}, 32);
         check("R8", n_unsup - e, 1);
         check("R8", n_upd - u, 0);
      end
      check_bank("R8");

      // R9 surplus bits in a frame
      u = n_upd; e = n_ferr;
      send({mk(1'b0, 3'b000, 4'h0, 4'd6, 16'h4321, 4'h0), 32'hFFFFFFFF} >> 24, 40);
      model[6] = 16'h4321;
      check("R9", n_upd - u, 1);
      check("R9", n_ferr - e, 0);
      check_bank("R9");

      // R10 clocking while frame select high shifts nothing
      din = 1'b1;
      for (int i = 0; i < 20; i++) begin
         wait_clk(HALF); sclk = 1'b0; wait_clk(HALF); sclk = 1'b1;
      end
      wait_clk(12);
      check("R10", n_upd - u, 1);
      check_bank("R10");
      write_ok("R10", mk(1'b0, 3'b000, 4'h0, 4'd7, 16'h0F0F, 4'h0));
      check_bank("R10");

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule